// File: doc/BRIEF.md
# Periodic Link Training Scheduler

This block sits on the sending side of a source-synchronous packet interface of the SPI-4.2 kind. It decides when de-skew training is placed between payload bursts. On every cycle it gives a downstream word emitter a two-bit word-type code. The code selects a payload slot, an idle control word, a training control word or a training data word. The emitter holds fixed patterns for the two training word types, and the two patterns are orthogonal.

A gap timer counts the cycles since the last training sequence began. Once the programmed limit is reached, the block inserts a new sequence. A limit of zero turns periodic training off. Until the link has been provisioned, sequences run back to back without any limit. Each sequence opens with one idle control word. This keeps the parity carried by the training control words free of the data words that came before it. One or more repetitions follow, each made of `PAT_LEN` training control words and then `PAT_LEN` training data words. The usual repetition setting is 32.

If the limit expires during a payload burst, the sequence waits until the burst ends. A busy output tells the payload scheduler to stall for the whole sequence. The transmit and receive directions each use their own instance of the block.

Top module: `lnk_train_sched`

## Requirements
- R1: While reset is held and in the cycle after it is released, `word_sel` is 0 and `busy` is 0. The `word_sel` codes are: 0 payload slot, 1 idle control word, 2 training control word, 3 training data word.
- R2: This requirement covers `provisioned` high, `max_interval` M nonzero and `burst_active` low. The first idle word appears M cycles after the first post-reset cycle, which is cycle 0. Later idle words appear every max(M, S) cycles, where S = 1 + 2·PAT_LEN·reps is the sequence length.
- R3: When `provisioned` is high and `max_interval` is 0, `word_sel` stays 0 and no sequence starts.
- R4: A sequence is one idle word (code 1). Each repetition then gives exactly PAT_LEN codes of 2 followed by exactly PAT_LEN codes of 3, with no gap between them.
- R5: The number of repetitions equals `rep_count`, and a value of 0 counts as 1. The value is captured when the idle word is issued, so later changes have no effect on the sequence already running.
- R6: While `provisioned` is low and no burst is active, the first idle word appears in cycle 1. Each sequence is followed at once by the next one, with no payload slot in between.
- R7: No sequence starts after a cycle in which `burst_active` is sampled high. If the limit expired during a burst, the idle word appears in the cycle after the first cycle with `burst_active` low. The gap timer restarts from that idle word, so the next idle word appears M cycles later.
- R8: `busy` is high exactly in the cycles where `word_sel` is not 0.
- R9: If the link becomes provisioned during a sequence, that sequence still finishes all of its repetitions. After that, sequences follow the interval rule, which means none at all when M = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| max_interval | input | CNT_W | Longest gap in cycles between sequence starts; 0 disables periodic training |
| rep_count | input | REP_W | Repetitions per sequence; 0 counts as 1 |
| provisioned | input | 1 | Link provisioned; low forces continuous training |
| burst_active | input | 1 | A payload burst is in progress and must not be cut |
| word_sel | output | 2 | Word type for the emitter: 0 payload, 1 idle, 2 training control, 3 training data |
| busy | output | 1 | Training sequence in progress; the payload scheduler stalls |

## Verification
The assertions assume that the payload scheduler obeys `busy`: `burst_active` never rises while a sequence is running, or in the cycle right after `busy` rises. The bench meets this by raising `burst_active` only while `word_sel` shows payload and well before the limit expires. It always lowers the signal before any sequence may start. The sweeps keep `max_interval`, `rep_count` and `provisioned` constant for the whole run. The one exception is the provisioning test, which changes them in the middle of a sequence on purpose to show that the captured repetition count and the running sequence are left alone.

// File: rtl/lts_pkg.sv
`timescale 1ns/1ps
package lts_pkg;
  // Word type handed to the downstream emitter (code values are part of R1)
  typedef enum logic [1:0] {
    WS_PAYLOAD = 2'd0,
    WS_IDLE    = 2'd1,
    WS_TCTL    = 2'd2,
    WS_TDAT    = 2'd3
  } word_t;
endpackage

// File: rtl/lts_gap_timer.sv
`timescale 1ns/1ps
module lts_gap_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] max_interval,
  input  logic             seq_start,
  output logic             due
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] gap_q;

  // Counts cycles since the most recent idle word; saturates at all-ones
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (seq_start) begin
      gap_q <= '0;
    end else if (gap_q != CNT_MAX) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // Due one cycle ahead so the idle word lands exactly max_interval cycles apart
  always_comb begin
    due = 1'b0;
    if (max_interval != '0) begin
      due = (gap_q >= (max_interval - 1'b1));
    end
  end
endmodule

// File: rtl/lts_seq_ctrl.sv
`timescale 1ns/1ps
module lts_seq_ctrl
  import lts_pkg::*;
#(
  parameter int PAT_LEN = 10,
  parameter int REP_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             due,
  input  logic             provisioned,
  input  logic             burst_active,
  input  logic [REP_W-1:0] rep_count,
  output logic             seq_start,
  output word_t            word_q,
  output logic             busy_q
);
  localparam int PW = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;
  localparam logic [PW-1:0] W_LAST = PW'(PAT_LEN - 1);

  word_t            st_d;
  logic [PW-1:0]    wcnt_q;
  logic [REP_W-1:0] rcnt_q;
  logic [REP_W-1:0] rlast_q;
  logic             want;
  logic             pat_end;
  logic             rep_end;

  assign want    = !burst_active && (due || !provisioned);
  assign pat_end = (wcnt_q == W_LAST);
  assign rep_end = (rcnt_q == rlast_q);

  always_comb begin
    st_d = word_q;
    unique case (word_q)
      WS_PAYLOAD: if (want) st_d = WS_IDLE;
      WS_IDLE:    st_d = WS_TCTL;
      WS_TCTL:    if (pat_end) st_d = WS_TDAT;
      WS_TDAT: begin
        if (pat_end) begin
          if (!rep_end)  st_d = WS_TCTL;
          else if (want) st_d = WS_IDLE;
          else           st_d = WS_PAYLOAD;
        end
      end
      default:    st_d = WS_PAYLOAD;
    endcase
  end

  assign seq_start = (st_d == WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= WS_PAYLOAD;
      busy_q  <= 1'b0;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      rlast_q <= '0;
    end else begin
      word_q <= st_d;
      busy_q <= (st_d != WS_PAYLOAD);
      if (seq_start) begin
        wcnt_q  <= '0;
        rcnt_q  <= '0;
        rlast_q <= (rep_count == '0) ? '0 : (rep_count - 1'b1);
      end else if (word_q == WS_TCTL || word_q == WS_TDAT) begin
        wcnt_q <= pat_end ? '0 : (wcnt_q + 1'b1);
        if (word_q == WS_TDAT && pat_end && !rep_end) begin
          rcnt_q <= rcnt_q + 1'b1;
        end
      end
    end
  end

  // R4: the idle word is followed directly by a training control word
  assert_idle_to_ctl_R4: assert property (@(posedge clk) disable iff (rst)
    (word_q == WS_IDLE) |=> (word_q == WS_TCTL));

  // R4: control words hand over to data words only after a full pattern
  assert_ctl_len_R4: assert property (@(posedge clk) disable iff (rst)
    (word_q == WS_TDAT && $past(word_q) == WS_TCTL) |-> ($past(wcnt_q) == W_LAST));

  // R5: repetition index never passes the captured last repetition
  assert_rep_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (word_q == WS_TCTL || word_q == WS_TDAT) |-> (rcnt_q <= rlast_q));
endmodule

// File: rtl/lnk_train_sched.sv
`timescale 1ns/1ps
module lnk_train_sched
  import lts_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int REP_W   = 6,
  parameter int PAT_LEN = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] max_interval,
  input  logic [REP_W-1:0] rep_count,
  input  logic             provisioned,
  input  logic             burst_active,
  output logic [1:0]       word_sel,
  output logic             busy
);
  logic  due;
  logic  seq_start;
  word_t word_q;
  logic  busy_q;

  lts_gap_timer #(.CNT_W(CNT_W)) gap_i (
    .clk          (clk),
    .rst          (rst),
    .max_interval (max_interval),
    .seq_start    (seq_start),
    .due          (due)
  );

  lts_seq_ctrl #(.PAT_LEN(PAT_LEN), .REP_W(REP_W)) seq_i (
    .clk          (clk),
    .rst          (rst),
    .due          (due),
    .provisioned  (provisioned),
    .burst_active (burst_active),
    .rep_count    (rep_count),
    .seq_start    (seq_start),
    .word_q       (word_q),
    .busy_q       (busy_q)
  );

  assign word_sel = word_q;
  assign busy     = busy_q;

  // R2: an expired gap with no burst opens a sequence in the next cycle
  assert_due_start_R2: assert property (@(posedge clk) disable iff (rst)
    (due && !burst_active && word_sel == 2'd0) |=> (word_sel == 2'd1));

  // R3: disabled interval on a provisioned link keeps payload slots
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (max_interval == '0 && provisioned && word_sel == 2'd0) |=> (word_sel == 2'd0));

  // R7: no sequence starts behind a burst that is still running
  assert_no_start_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
    (burst_active && word_sel == 2'd0) |=> (word_sel == 2'd0));

  // R8: busy mirrors any non-payload word type
  assert_busy_match_R8: assert property (@(posedge clk) disable iff (rst)
    busy == (word_sel != 2'd0));
endmodule

// File: tb/lnk_train_sched_tb_top.sv
`timescale 1ns/1ps
module lnk_train_sched_tb_top;
  localparam int CW = 8;
  localparam int RW = 3;
  localparam int PL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] max_interval = '0;
  logic [RW-1:0] rep_count = '0;
  logic          provisioned = 1'b0;
  logic          burst_active = 1'b0;
  logic [1:0]    word_sel;
  logic          busy;

  int n_chk = 0;
  int n_bad = 0;

  always #2ns clk = ~clk;

  lnk_train_sched #(.CNT_W(CW), .REP_W(RW), .PAT_LEN(PL)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .max_interval (max_interval),
    .rep_count    (rep_count),
    .provisioned  (provisioned),
    .burst_active (burst_active),
    .word_sel     (word_sel),
    .busy         (busy)
  );

  task automatic chk(input string req, input int act, input int exp, input int t);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, t, act, exp);
    end
  endtask

  // Word code expected in cycle t (cycle 0 = first cycle after reset release)
  function automatic int exp_word(input int t, input int m, input int r, input bit prov);
    int me, s, p, off, q;
    if (prov && m == 0) return 0;
    me  = prov ? m : 1;
    s   = 1 + 2 * PL * ((r == 0) ? 1 : r);
    p   = (me > s) ? me : s;
    if (t < me) return 0;
    off = (t - me) % p;
    if (off >= s) return 0;
    if (off == 0) return 1;
    q = (off - 1) % (2 * PL);
    return (q < PL) ? 2 : 3;
  endfunction

  task automatic do_reset(input bit check_it);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    if (check_it) begin
      #1ns;
      chk("R1 word_sel in reset", int'(word_sel), 0, -1);
      chk("R1 busy in reset", int'(busy), 0, -1);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sweep(input int m, input int r, input bit prov, input int n);
    string tag;
    int    e;
    max_interval = CW'(m);
    rep_count    = RW'(r);
    provisioned  = prov;
    burst_active = 1'b0;
    do_reset(1'b0);
    for (int t = 0; t < n; t++) begin
      #1ns;
      e = exp_word(t, m, r, prov);
      if (t == 0)         tag = "R1";
      else if (!prov)     tag = "R6";
      else if (m == 0)    tag = "R3";
      else if (e == 0)    tag = "R2";
      else if (r > 1)     tag = "R5";
      else                tag = "R4";
      chk(tag, int'(word_sel), e, t);
      chk("R8", int'(busy), (e != 0) ? 1 : 0, t);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4ns);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int e;
    // R1: reset state after activity
    provisioned = 1'b0;
    rep_count   = 3'd1;
    do_reset(1'b0);
    repeat (7) @(negedge clk);
    do_reset(1'b1);

    // R2 R3 R4 R5: provisioned sweep over interval and repetition settings
    for (int m = 0; m <= 20; m++) begin
      for (int r = 0; r <= 3; r++) begin
        sweep(m, r, 1'b1, 70);
      end
    end
    // R6: continuous training before provisioning
    for (int r = 0; r <= 3; r++) begin
      sweep(9, r, 1'b0, 80);
    end

    // R7: limit 30 expires inside a burst held for cycles 10..44
    max_interval = 8'd30;
    rep_count    = 3'd1;
    provisioned  = 1'b1;
    burst_active = 1'b0;
    do_reset(1'b0);
    for (int t = 0; t < 110; t++) begin
      burst_active = (t >= 10 && t < 45);
      #1ns;
      e = (t < 46) ? 0 : exp_word(t - 46 + 30, 30, 1, 1'b1);
      chk("R7", int'(word_sel), e, t);
      chk("R8", int'(busy), (e != 0) ? 1 : 0, t);
      @(negedge clk);
    end
    burst_active = 1'b0;

    // R9 R5: provisioned with limit 0 and rep_count cleared during the first sequence
    max_interval = 8'd0;
    rep_count    = 3'd2;
    provisioned  = 1'b0;
    do_reset(1'b0);
    for (int t = 0; t < 100; t++) begin
      if (t == 5) begin
        provisioned = 1'b1;
        rep_count   = 3'd0;
      end
      #1ns;
      e = (t <= 17) ? exp_word(t, 1, 2, 1'b0) : 0;
      chk((t <= 17) ? "R5" : "R9", int'(word_sel), e, t);
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule